// File: doc/BRIEF.md
# Scaled-Index Load Unit

This unit carries out one scaled-index integer load for a 64-bit register machine. An issuing stage hands it two register values (base and index), the register numbers of the base and the target, a 2-bit scale, an access size, a sign-extension flag, a byte-swap flag and an update flag. The unit forms the effective address as base plus the index shifted left by one more than the scale. It issues a single read to memory, then turns the returned bytes into a 64-bit register value. In update form it also hands back the effective address, which is written into the base register.

The issue side is a valid/ready stream. `req_ready` is high only when the unit is idle. An operation is taken on the first rising edge where `req_valid` and `req_ready` are both high, and the unit stays busy until its `done` pulse. The memory request is also valid/ready. Once `mem_req_valid` rises it stays high, with `mem_addr` and `mem_size` frozen, until an edge where `mem_req_ready` is high. The memory answers with a single-cycle `mem_rsp_valid`, at least one cycle after that edge. The response cannot be back-pressured. Operand decode, the register file, exceptions and stores are handled elsewhere.

Top module: `sxload_unit`

## Requirements
- R1: The effective address equals the base term plus `index_val` shifted left by `scale`+1 bits, so the shift is 1 to 4 bits. The addition is 64 bits wide and wraps, bits shifted out of the top are lost, and no alignment check is made. The address is presented on `mem_addr`.
- R2: When `upd` is 0 and `base_sel` is 0, the base term is zero. When `upd` is 0 and `base_sel` is not 0, the base term is `base_val`.
- R3: When `upd` is 1 and the form is legal, the base term is always `base_val`. The `done` cycle shows `base_we`=1, `base_data` equal to the effective address, and `base_idx` equal to `base_sel`. `base_we` is never high without `dest_we`.
- R4: An update form is legal only when `base_sel` is nonzero and differs from `dest_sel`. When it is not legal, the `done` cycle shows `illegal`=1, `dest_we`=0 and `base_we`=0, and no memory request is issued.
- R5: `size` is coded 0=byte, 1=halfword, 2=word, 3=doubleword, giving N = 1, 2, 4 or 8 bytes. The access occupies the low 8N bits of `mem_rsp_data`, with the byte at the effective address in the most significant of those lanes; the other bits are ignored. With `sext`=0 and `brev`=0, the result is the low 8N bits with zeros above.
- R6: With `sext`=1 on a halfword or word, the result is the low 8N bits of the response, sign-extended to 64 bits.
- R7: A doubleword load returns all 64 response bits unchanged when `brev`=0, whatever `sext` is.
- R8: With `brev`=1 on a halfword, word or doubleword, the N bytes are placed in reverse order, so the byte at the effective address becomes the least significant byte. The result is zero-extended.
- R9: The forms that do not exist are treated exactly like an illegal update form (R4). These are a byte with `sext`=1, a byte with `brev`=1, and any size with both `sext`=1 and `brev`=1.
- R10: A legal operation issues exactly one memory request. `mem_size` equals `size` while the request is valid. `mem_req_valid`, `mem_addr` and `mem_size` stay stable until the request is accepted. `mem_rsp_valid` counts only after the request has been accepted.
- R11: `done` is a one-cycle pulse. `req_ready` is low from the cycle after acceptance through the `done` cycle, so only one operation is ever outstanding. It is high again the cycle after `done`.
- R12: For a legal operation, `done` is high in the cycle right after the edge that samples `mem_rsp_valid`. For an illegal operation, `done` is high in the cycle right after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Operation offered |
| req_ready | output | 1 | Unit idle and able to take an operation |
| base_val | input | 64 | Contents of the base register |
| index_val | input | 64 | Contents of the index register |
| base_sel | input | 5 | Base register number |
| dest_sel | input | 5 | Target register number |
| scale | input | 2 | Scale field; the index shift is scale+1 |
| size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 double) |
| sext | input | 1 | Sign-extend the loaded value |
| brev | input | 1 | Reverse byte order of the loaded value |
| upd | input | 1 | Update form: write the effective address to the base register |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 64 | Read address |
| mem_size | output | 2 | Read size code |
| mem_rsp_valid | input | 1 | Read data valid, one cycle |
| mem_rsp_data | input | 64 | Read data, access in the low lanes, big-endian |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Completed operation was an illegal form |
| dest_we | output | 1 | Write target register |
| dest_idx | output | 5 | Target register number |
| dest_data | output | 64 | Formatted load result |
| base_we | output | 1 | Write base register |
| base_idx | output | 5 | Base register number |
| base_data | output | 64 | Effective address for base writeback |

## Verification
The address is checked against a reference value when the memory request is accepted. That acceptance happens one edge or more after the issue edge, depending on how the memory drives `mem_req_ready`. The formatted result and both write enables are due in the single cycle after the edge that samples `mem_rsp_valid`. For illegal forms they are due in the cycle right after the issue edge. The bench runs its memory model and its checks on falling edges and counts those edges. It compares the edge on which it sees `done` with the edge on which it raised the response, and it also checks that `done` is gone one edge later. The response latency and the memory's willingness to accept vary from one operation to the next, so that this timing is exercised over a range of cases.

// File: rtl/sxl_pkg.sv
`timescale 1ns/1ps
package sxl_pkg;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } sz_e;

  typedef struct packed {
    sz_e  size;
    logic sext;
    logic brev;
  } fmt_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } st_e;

endpackage

// File: rtl/sxl_agen.sv
`timescale 1ns/1ps
module sxl_agen #(
  parameter int XLEN  = 64,
  parameter int SEL_W = 5,
  parameter int SC_W  = 2
) (
  input  logic [XLEN-1:0]  base_val,
  input  logic [XLEN-1:0]  index_val,
  input  logic [SEL_W-1:0] base_sel,
  input  logic [SC_W-1:0]  scale,
  input  logic             upd,
  output logic [XLEN-1:0]  ea
);
  localparam int SH_W = SC_W + 1;

  logic [SH_W-1:0] shamt;
  logic [XLEN-1:0] base_term;
  logic [XLEN-1:0] scaled;

  // register 0 reads as zero only in the non-update forms
  assign base_term = (!upd && base_sel == '0) ? '0 : base_val;
  assign shamt     = SH_W'(scale) + SH_W'(1);
  assign scaled    = index_val << shamt;
  assign ea        = base_term + scaled;

endmodule

// File: rtl/sxl_legal.sv
`timescale 1ns/1ps
module sxl_legal
  import sxl_pkg::*;
#(
  parameter int SEL_W = 5
) (
  input  fmt_t             fmt,
  input  logic             upd,
  input  logic [SEL_W-1:0] base_sel,
  input  logic [SEL_W-1:0] dest_sel,
  output logic             bad
);
  logic form_bad;
  logic upd_bad;

  assign form_bad = (fmt.size == SZ_B && (fmt.sext || fmt.brev)) ||
                    (fmt.sext && fmt.brev);
  assign upd_bad  = upd && (base_sel == '0 || base_sel == dest_sel);
  assign bad      = form_bad || upd_bad;

endmodule

// File: rtl/sxl_format.sv
`timescale 1ns/1ps
module sxl_format
  import sxl_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  fmt_t            fmt,
  input  logic [XLEN-1:0] raw,
  output logic [XLEN-1:0] result
);
  localparam int BYTES = XLEN / 8;
  localparam int NSZ   = $clog2(BYTES) + 1;

  logic [XLEN-1:0] zx_v [NSZ];
  logic [XLEN-1:0] sx_v [NSZ];
  logic [XLEN-1:0] rv_v [NSZ];

  for (genvar gs = 0; gs < NSZ; gs++) begin : g_sz
    localparam int NB = 1 << gs;
    logic [XLEN-1:0] swapped;

    always_comb begin
      swapped = '0;
      for (int b = 0; b < NB; b++) begin
        swapped[8*b +: 8] = raw[8*(NB-1-b) +: 8];
      end
    end
    assign rv_v[gs] = swapped;

    if (NB < BYTES) begin : g_ext
      assign zx_v[gs] = {{(XLEN-8*NB){1'b0}}, raw[8*NB-1:0]};
      assign sx_v[gs] = {{(XLEN-8*NB){raw[8*NB-1]}}, raw[8*NB-1:0]};
    end else begin : g_full
      assign zx_v[gs] = raw;
      assign sx_v[gs] = raw;
    end
  end

  always_comb begin
    if (fmt.brev)      result = rv_v[fmt.size];
    else if (fmt.sext) result = sx_v[fmt.size];
    else               result = zx_v[fmt.size];
  end

  // zero-extending paths leave everything above the access clear
  always_comb begin
    if (!fmt.sext && fmt.size != SZ_D) begin
      p_zero_fill_r5: assert ((result >> (8 << fmt.size)) == '0)
        else $error("upper bits not zero");
    end
  end

endmodule

// File: rtl/sxl_ctrl.sv
`timescale 1ns/1ps
module sxl_ctrl
  import sxl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic bad,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  output logic req_ready,
  output logic accept,
  output logic mem_req_valid,
  output logic rsp_take,
  output logic done
);
  st_e st_q, st_d;

  assign req_ready     = (st_q == ST_IDLE);
  assign accept        = req_ready && req_valid;
  assign mem_req_valid = (st_q == ST_REQ);
  assign rsp_take      = (st_q == ST_WAIT) && mem_rsp_valid;
  assign done          = (st_q == ST_DONE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = bad ? ST_DONE : ST_REQ;
      ST_REQ:  if (mem_req_ready) st_d = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid)
    else $error("request dropped before acceptance");

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done longer than one cycle");

  p_busy_after_issue_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready)
    else $error("ready while busy");

  p_done_then_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready)
    else $error("not ready after done");

  p_illegal_fast_r12: assert property (@(posedge clk) disable iff (!rst_n)
    accept && bad |=> done)
    else $error("illegal op not completed next cycle");

endmodule

// File: rtl/sxload_unit.sv
`timescale 1ns/1ps
module sxload_unit
  import sxl_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int SEL_W = 5,
  parameter int SC_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [XLEN-1:0]  base_val,
  input  logic [XLEN-1:0]  index_val,
  input  logic [SEL_W-1:0] base_sel,
  input  logic [SEL_W-1:0] dest_sel,
  input  logic [SC_W-1:0]  scale,
  input  logic [1:0]       size,
  input  logic             sext,
  input  logic             brev,
  input  logic             upd,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [XLEN-1:0]  mem_addr,
  output logic [1:0]       mem_size,
  input  logic             mem_rsp_valid,
  input  logic [XLEN-1:0]  mem_rsp_data,
  output logic             done,
  output logic             illegal,
  output logic             dest_we,
  output logic [SEL_W-1:0] dest_idx,
  output logic [XLEN-1:0]  dest_data,
  output logic             base_we,
  output logic [SEL_W-1:0] base_idx,
  output logic [XLEN-1:0]  base_data
);
  fmt_t            fmt_in;
  fmt_t            fmt_q;
  logic [XLEN-1:0] ea;
  logic [XLEN-1:0] ea_q;
  logic [XLEN-1:0] fmt_out;
  logic [XLEN-1:0] res_q;
  logic [SEL_W-1:0] dsel_q, bsel_q;
  logic            bad, bad_q, upd_q;
  logic            accept, rsp_take;

  assign fmt_in = '{size: sz_e'(size), sext: sext, brev: brev};

  sxl_agen #(.XLEN(XLEN), .SEL_W(SEL_W), .SC_W(SC_W)) u_agen (
    .base_val (base_val),
    .index_val(index_val),
    .base_sel (base_sel),
    .scale    (scale),
    .upd      (upd),
    .ea       (ea)
  );

  sxl_legal #(.SEL_W(SEL_W)) u_legal (
    .fmt     (fmt_in),
    .upd     (upd),
    .base_sel(base_sel),
    .dest_sel(dest_sel),
    .bad     (bad)
  );

  sxl_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .bad          (bad),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .req_ready    (req_ready),
    .accept       (accept),
    .mem_req_valid(mem_req_valid),
    .rsp_take     (rsp_take),
    .done         (done)
  );

  sxl_format #(.XLEN(XLEN)) u_fmt (
    .fmt   (fmt_q),
    .raw   (mem_rsp_data),
    .result(fmt_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q   <= '0;
      fmt_q  <= '{size: SZ_B, sext: 1'b0, brev: 1'b0};
      upd_q  <= 1'b0;
      bad_q  <= 1'b0;
      dsel_q <= '0;
      bsel_q <= '0;
    end else if (accept) begin
      ea_q   <= ea;
      fmt_q  <= fmt_in;
      upd_q  <= upd;
      bad_q  <= bad;
      dsel_q <= dest_sel;
      bsel_q <= base_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        res_q <= '0;
    else if (rsp_take) res_q <= fmt_out;
  end

  assign mem_addr  = ea_q;
  assign mem_size  = fmt_q.size;
  assign illegal   = done && bad_q;
  assign dest_we   = done && !bad_q;
  assign base_we   = done && !bad_q && upd_q;
  assign dest_idx  = dsel_q;
  assign base_idx  = bsel_q;
  assign dest_data = res_q;
  assign base_data = ea_q;

  p_req_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> $stable(mem_addr) && $stable(mem_size))
    else $error("request fields moved while waiting");

  p_illegal_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !dest_we && !base_we)
    else $error("write during illegal completion");

  p_base_with_dest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |-> dest_we)
    else $error("base write without target write");

  p_rsp_to_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take |=> done && !illegal)
    else $error("response not completed next cycle");

endmodule

// File: tb/sxload_unit_test.sv
`timescale 1ns/1ps
module sxload_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [63:0] base_val, index_val;
  logic [4:0]  base_sel, dest_sel;
  logic [1:0]  scale, size;
  logic        sext, brev, upd;
  logic        mem_req_valid, mem_req_ready;
  logic [63:0] mem_addr;
  logic [1:0]  mem_size;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        done, illegal, dest_we, base_we;
  logic [4:0]  dest_idx, base_idx;
  logic [63:0] dest_data, base_data;

  always #2.5 clk = ~clk;

  sxload_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .base_val(base_val), .index_val(index_val), .base_sel(base_sel),
    .dest_sel(dest_sel), .scale(scale), .size(size), .sext(sext),
    .brev(brev), .upd(upd), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .illegal(illegal), .dest_we(dest_we), .dest_idx(dest_idx),
    .dest_data(dest_data), .base_we(base_we), .base_idx(base_idx),
    .base_data(base_data)
  );

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mb(input logic [63:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ a[63:56] ^ 8'h5c;
  endfunction

  // memory model, runs on falling edges
  logic [15:0] lfsr = 16'hACE1;
  int          ncyc = 0;
  int          rsp_cnt = 0;
  int          rsp_stamp = 0;
  int          hs_count = 0;
  logic [63:0] hs_addr = '0;
  logic [1:0]  hs_size = '0;

  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
  end

  always @(negedge clk) begin
    logic        r;
    logic [63:0] v, mask;
    int          n;
    ncyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_rsp_valid = 1'b0;
    if (rsp_cnt > 0) begin
      rsp_cnt--;
      if (rsp_cnt == 0) begin
        n = 1 << hs_size;
        v = '0;
        for (int i = 0; i < n; i++) v = (v << 8) | 64'(mb(hs_addr + 64'(i)));
        mask = (64'd1 << (8 * n)) - 64'd1;
        mem_rsp_data  = ({32'hA5C3_0F1E, 16'h9B7D, lfsr} & ~mask) | v;
        mem_rsp_valid = 1'b1;
        rsp_stamp     = ncyc;
      end
    end
    r = lfsr[0] | lfsr[1];
    mem_req_ready = r;
    if (rst_n && mem_req_valid && r) begin
      hs_count++;
      hs_addr = mem_addr;
      hs_size = mem_size;
      rsp_cnt = 1 + int'(lfsr[3:2]);
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic run_op(input logic [63:0] b, input logic [63:0] x,
                        input logic [4:0] bs, input logic [4:0] ds,
                        input logic [1:0] sc, input logic [1:0] sz,
                        input logic sx, input logic rv, input logic up);
    logic        exp_bad;
    logic [63:0] bterm, ea, v, rvv;
    int          n, cyc, hs0;
    string       tag;
    exp_bad = (up && (bs == 0 || bs == ds)) || (sz == 0 && (sx || rv)) || (sx && rv);
    bterm   = (!up && bs == 0) ? 64'd0 : b;
    ea      = bterm + (x << (int'(sc) + 1));
    n       = 1 << sz;
    v = '0; rvv = '0;
    for (int i = 0; i < n; i++) begin
      v   = (v << 8) | 64'(mb(ea + 64'(i)));
      rvv = rvv | (64'(mb(ea + 64'(i))) << (8 * i));
    end
    if (sx && sz != 2'd3 && v[8*n-1]) v = v | (~64'd0 << (8 * n));
    if (rv) v = rvv;
    tag = rv ? "R8" : (sz == 2'd3) ? "R7" : sx ? "R6" : "R5";

    base_val = b; index_val = x; base_sel = bs; dest_sel = ds;
    scale = sc; size = sz; sext = sx; brev = rv; upd = up;
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R11 ready when idle", 64'(req_ready), 64'd1);
    hs0 = hs_count;
    tick();
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11 busy after issue", 64'(req_ready), 64'd0);
    cyc = 1;
    while (!done && cyc < 100) begin
      tick();
      cyc++;
    end
    if (!done) begin
      chk(1'b0, "R11 watchdog waiting for done", 64'(cyc), 64'd100);
      return;
    end
    chk(illegal == exp_bad, exp_bad ? (up ? "R4 illegal flag" : "R9 illegal flag")
                                    : "R9 legal flag", 64'(illegal), 64'(exp_bad));
    chk(dest_we == !exp_bad, "R4 target write enable", 64'(dest_we), 64'(!exp_bad));
    chk(base_we == (!exp_bad && up), "R3 base write enable", 64'(base_we),
        64'(!exp_bad && up));
    if (exp_bad) begin
      chk(cyc == 1, "R12 illegal done latency", 64'(cyc), 64'd1);
      chk(hs_count == hs0, "R4 R9 no memory request", 64'(hs_count), 64'(hs0));
    end else begin
      chk(hs_count == hs0 + 1, "R10 one request", 64'(hs_count), 64'(hs0 + 1));
      chk(hs_addr == ea, up ? "R1 R3 address" : "R1 R2 address", hs_addr, ea);
      chk(hs_size == sz, "R10 request size", 64'(hs_size), 64'(sz));
      chk(ncyc == rsp_stamp + 1, "R12 done after response", 64'(ncyc),
          64'(rsp_stamp + 1));
      chk(dest_data == v, tag, dest_data, v);
      chk(dest_idx == ds, "R5 target index", 64'(dest_idx), 64'(ds));
      if (up) begin
        chk(base_data == ea, "R3 base data", base_data, ea);
        chk(base_idx == bs, "R3 base index", 64'(base_idx), 64'(bs));
      end
    end
    tick();
    chk(done == 1'b0, "R11 done single pulse", 64'(done), 64'd0);
    chk(req_ready == 1'b1, "R11 ready after done", 64'(req_ready), 64'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] bv [3];
    logic [63:0] xv [3];
    logic [4:0]  bsv [3];
    bv[0] = 64'h1000_0000_0000_0F00; xv[0] = 64'h0000_0000_0000_0037;
    bv[1] = 64'hFFFF_FFFF_FFFF_FFF0; xv[1] = 64'h0000_0000_0000_0009;
    bv[2] = 64'h0123_4567_89AB_CDEF; xv[2] = 64'hF000_0000_0000_0101;
    bsv[0] = 5'd0; bsv[1] = 5'd7; bsv[2] = 5'd12;

    rst_n = 1'b0; req_valid = 1'b0;
    base_val = '0; index_val = '0; base_sel = '0; dest_sel = '0;
    scale = '0; size = '0; sext = 1'b0; brev = 1'b0; upd = 1'b0;
    repeat (3) tick();
    chk(req_ready == 1'b1, "R11 reset ready", 64'(req_ready), 64'd1);
    chk(done == 1'b0, "R11 reset done", 64'(done), 64'd0);
    chk(mem_req_valid == 1'b0, "R10 reset request", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;
    tick();

    for (int o = 0; o < 3; o++)
      for (int s = 0; s < 3; s++)
        for (int u = 0; u < 2; u++)
          for (int sz = 0; sz < 4; sz++)
            for (int sx = 0; sx < 2; sx++)
              for (int rv = 0; rv < 2; rv++)
                for (int sc = 0; sc < 4; sc++)
                  run_op(bv[o], xv[o], bsv[s], 5'd7, 2'(sc), 2'(sz),
                         1'(sx), 1'(rv), 1'(u));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule